// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Queue

This block holds dispatched micro-operations of a small out-of-order core until they may issue. Each incoming entry carries a sequence number, a destination tag, two source tags with their ready bits, and a flag that marks it non-speculative. The queue listens to a wake-up broadcast. It picks the oldest ready entries, up to the issue width less the slots already taken this cycle, and hands them out on parallel lanes with a valid/ready handshake.

Every slot is a small state machine with four states. **FREE** means the slot is empty. **WAIT** means it is occupied and waits for operands. **READY** means it may be selected. **HOLD** means it is non-speculative and parked until commit releases it.

The transitions are:
- **ALLOC_WAIT**: FREE to WAIT, on dispatch with a missing source.
- **ALLOC_READY**: FREE to READY, on dispatch with all sources ready.
- **ALLOC_HOLD**: FREE to HOLD, on dispatch of a non-speculative entry.
- **WAKE**: WAIT to READY, once the last source is marked ready.
- **RELEASE**: HOLD to READY, when the release sequence number matches.
- **ISSUE**: READY to FREE, when the entry's lane is accepted.
- **SQUASH**: any occupied state to FREE, when the entry is younger than the squash point.

SQUASH overrides every other transition. Sequence numbers are one bit wider than the slot index, and they are compared modulo their width.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty: `occ_count` is 0, `full` is 0 and no bit of `out_valid` is set.
- R2: A speculative entry dispatched with both `disp_src_rdy` bits set (or matched by the wake-up of the same cycle) is offered on a lane in the cycle after the dispatch edge.
- R3: An entry dispatched with a missing source is not offered. A `wake_valid` broadcast whose `wake_tag` equals one of its source tags marks that source ready. The entry is offered in the cycle after the edge at which its last source became ready.
- R4: An entry dispatched with `disp_nonspec`=1 is never offered, whatever its source bits, until `rel_valid` presents its exact sequence number on `rel_seq`. It is offered in the cycle after that edge. A release with any other number leaves it held.
- R5: The number of set bits in `out_valid` never exceeds the budget. The budget is ISSUE_W minus `used_slots`, and it is 0 when `used_slots` is ISSUE_W or more. Lanes fill from lane 0 upward with no gap.
- R6: Lanes carry the oldest ready entries: lane 0 holds the oldest, and lane k+1 holds one younger than lane k, independent of the slot order.
- R7: With `out_ready`=1 every valid lane's entry leaves the queue at that edge. With `out_ready`=0 the offered entries stay in the queue.
- R8: `sq_valid` with number S frees, at that edge, every occupied entry (waiting, ready or held) that is younger than S. Entries equal to or older than S stay.
- R9: In a squash cycle, a wake-up or release aimed at a squashed entry has no effect, and a dispatch offered in that cycle is dropped.
- R10: `full` is 1 exactly when DEPTH entries are occupied. A dispatch offered while `full` is 1 is dropped.
- R11: `occ_count` equals the number of occupied slots and never exceeds DEPTH.
- R12: Age uses a sequence width of log2(DEPTH)+1 bits. A is younger than B when (A−B) modulo 2^width is non-zero and below 2^(width−1), so with 4 bits, 0 is younger than 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | 4 | Sequence number of the dispatched entry |
| disp_dst | input | 5 | Destination tag carried to the issue lane |
| disp_nonspec | input | 1 | Entry must wait for commit release |
| disp_src_tag | input | 10 | Two 5-bit source tags |
| disp_src_rdy | input | 2 | Source ready bits at dispatch |
| wake_valid | input | 1 | Wake-up broadcast valid |
| wake_tag | input | 5 | Tag of the producer being broadcast |
| rel_valid | input | 1 | Commit release valid |
| rel_seq | input | 4 | Sequence number released by commit |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 4 | Squash point; younger entries are removed |
| used_slots | input | 2 | Issue slots already taken this cycle |
| out_ready | input | 1 | Consumer accepts all valid lanes |
| out_valid | output | 2 | Per-lane valid |
| out_seq | output | 8 | Per-lane sequence number |
| out_dst | output | 10 | Per-lane destination tag |
| occ_count | output | 4 | Occupied slots |
| full | output | 1 | All slots occupied |

## Verification
The selection logic is tried with four kinds of pattern.

- Entries are dispatched in reverse age order across the sequence wrap point. This separates true oldest-first selection from picking by slot index or by unsigned compare.
- The `used_slots` value is stepped through 0 to 3 while the ready entries stay fixed. This separates budget arithmetic and saturation from a fixed lane count.
- A squash is combined with a wake-up, a release and a dispatch in the same cycle. This shows whether squash truly wins.
- Long random runs mix all inputs and back-pressure. They exercise ordering between waiting, held and ready entries as the queue fills, drains and wraps.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_HOLD  = 2'd3
    } slot_state_e;

    // a is younger than b under modulo-2^w arithmetic
    function automatic logic seq_after(input logic [15:0] a,
                                       input logic [15:0] b,
                                       input int          w);
        logic [15:0] diff;
        diff = (a - b) & ((16'd1 << w) - 16'd1);
        return (diff != 16'd0) && (diff[w-1] == 1'b0);
    endfunction

endpackage

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int SEQ_W = 4,
    parameter int TAG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc,
    input  logic [SEQ_W-1:0]           a_seq,
    input  logic [TAG_W-1:0]           a_dst,
    input  logic                       a_nonspec,
    input  logic [NSRC-1:0][TAG_W-1:0] a_tag,
    input  logic [NSRC-1:0]            a_rdy,
    input  logic                       wk_valid,
    input  logic [TAG_W-1:0]           wk_tag,
    input  logic                       rel_valid,
    input  logic [SEQ_W-1:0]           rel_seq,
    input  logic                       sq_valid,
    input  logic [SEQ_W-1:0]           sq_seq,
    input  logic                       issue_go,
    output slot_state_e                st_o,
    output logic [SEQ_W-1:0]           seq_o,
    output logic [TAG_W-1:0]           dst_o
);

    slot_state_e                st_q, st_d;
    logic [SEQ_W-1:0]           seq_q;
    logic [TAG_W-1:0]           dst_q;
    logic [NSRC-1:0][TAG_W-1:0] tag_q;
    logic [NSRC-1:0]            rdy_q, rdy_d;
    logic [NSRC-1:0]            rdy_cur, rdy_new;
    logic                       sq_hit, rel_hit;

    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            rdy_cur[s] = rdy_q[s] | (wk_valid && (tag_q[s] == wk_tag));
            rdy_new[s] = a_rdy[s] | (wk_valid && (a_tag[s] == wk_tag));
        end
        sq_hit  = sq_valid && seq_after(16'(seq_q), 16'(sq_seq), SEQ_W);
        rel_hit = rel_valid && (rel_seq == seq_q);
    end

    // next-state process
    always_comb begin
        st_d  = st_q;
        rdy_d = rdy_cur;
        unique case (st_q)
            ST_FREE: begin
                if (alloc) begin
                    rdy_d = rdy_new;
                    if (a_nonspec)     st_d = ST_HOLD;   // ALLOC_HOLD
                    else if (&rdy_new) st_d = ST_READY;  // ALLOC_READY
                    else               st_d = ST_WAIT;   // ALLOC_WAIT
                end
            end
            ST_WAIT:  if (&rdy_cur) st_d = ST_READY;      // WAKE
            ST_HOLD:  if (rel_hit)  st_d = ST_READY;      // RELEASE
            ST_READY: if (issue_go) st_d = ST_FREE;       // ISSUE
        endcase
        if ((st_q != ST_FREE) && sq_hit) st_d = ST_FREE;  // SQUASH wins
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_FREE;
            rdy_q <= '0;
            seq_q <= '0;
            dst_q <= '0;
            tag_q <= '0;
        end else begin
            st_q  <= st_d;
            rdy_q <= rdy_d;
            if ((st_q == ST_FREE) && alloc) begin
                seq_q <= a_seq;
                dst_q <= a_dst;
                tag_q <= a_tag;
            end
        end
    end

    // outputs
    always_comb begin
        st_o  = st_q;
        seq_o = seq_q;
        dst_o = dst_q;
    end

    // R8: a younger occupied entry is gone after the squash edge
    p_squash_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_FREE && sq_hit) |=> (st_q == ST_FREE));

    // R4: a held entry stays held without its own release
    p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !sq_valid && !(rel_valid && rel_seq == seq_q))
        |=> (st_q == ST_HOLD));

    // R7: an offered entry stays while not accepted
    p_ready_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY && !issue_go && !sq_valid) |=> (st_q == ST_READY));

endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] free_vec,
    output logic [DEPTH-1:0] pick,
    output logic             any_free
);

    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (free_vec[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
        any_free = found;
    end

endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 2,
    parameter int SEQ_W   = 4,
    parameter int TAG_W   = 5,
    parameter int BUD_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0]              ready_vec,
    input  logic [DEPTH-1:0][SEQ_W-1:0]   seq_arr,
    input  logic [DEPTH-1:0][TAG_W-1:0]   dst_arr,
    input  logic [BUD_W-1:0]              budget,
    output logic [DEPTH-1:0]              grant,
    output logic [ISSUE_W-1:0]            lane_valid,
    output logic [ISSUE_W-1:0][SEQ_W-1:0] lane_seq,
    output logic [ISSUE_W-1:0][TAG_W-1:0] lane_dst
);

    localparam int RANK_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][RANK_W-1:0] rank;

    // rank = number of ready entries older than this one
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rank[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if ((j != i) && ready_vec[j] &&
                    seq_after(16'(seq_arr[i]), 16'(seq_arr[j]), SEQ_W))
                    rank[i] = rank[i] + RANK_W'(1);
            end
            grant[i] = ready_vec[i] && (int'(rank[i]) < int'(budget));
        end
    end

    always_comb begin
        for (int k = 0; k < ISSUE_W; k++) begin
            lane_valid[k] = 1'b0;
            lane_seq[k]   = '0;
            lane_dst[k]   = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (grant[i] && (rank[i] == RANK_W'(k))) begin
                    lane_valid[k] = 1'b1;
                    lane_seq[k]   = seq_arr[i];
                    lane_dst[k]   = dst_arr[i];
                end
            end
        end
    end

    generate
        for (genvar k = 0; k + 1 < ISSUE_W; k++) begin : g_order
            // R6: each later lane holds a younger entry
            p_lane_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
                lane_valid[k+1] |->
                    seq_after(16'(lane_seq[k+1]), 16'(lane_seq[k]), SEQ_W));
        end
    endgenerate

endmodule

// File: rtl/issue_queue.sv
module issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 2,
    parameter int NSRC    = 2,
    parameter int TAG_W   = 5,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int SEQ_W  = IDX_W + 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int USED_W = $clog2(ISSUE_W + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          disp_valid,
    input  logic [SEQ_W-1:0]              disp_seq,
    input  logic [TAG_W-1:0]              disp_dst,
    input  logic                          disp_nonspec,
    input  logic [NSRC-1:0][TAG_W-1:0]    disp_src_tag,
    input  logic [NSRC-1:0]               disp_src_rdy,
    input  logic                          wake_valid,
    input  logic [TAG_W-1:0]              wake_tag,
    input  logic                          rel_valid,
    input  logic [SEQ_W-1:0]              rel_seq,
    input  logic                          sq_valid,
    input  logic [SEQ_W-1:0]              sq_seq,
    input  logic [USED_W-1:0]             used_slots,
    input  logic                          out_ready,
    output logic [ISSUE_W-1:0]            out_valid,
    output logic [ISSUE_W-1:0][SEQ_W-1:0] out_seq,
    output logic [ISSUE_W-1:0][TAG_W-1:0] out_dst,
    output logic [CNT_W-1:0]              occ_count,
    output logic                          full
);

    slot_state_e                st_arr [DEPTH];
    logic [DEPTH-1:0][SEQ_W-1:0] seq_arr;
    logic [DEPTH-1:0][TAG_W-1:0] dst_arr;
    logic [DEPTH-1:0]            free_vec, ready_vec, pick, grant;
    logic                        any_free, alloc_go;
    logic [USED_W-1:0]           budget;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            free_vec[i]  = (st_arr[i] == ST_FREE);
            ready_vec[i] = (st_arr[i] == ST_READY);
        end
    end

    always_comb begin
        occ_count = '0;
        for (int i = 0; i < DEPTH; i++)
            occ_count = occ_count + CNT_W'(!free_vec[i]);
        full = (occ_count == CNT_W'(DEPTH));
    end

    always_comb begin
        if (used_slots >= USED_W'(ISSUE_W)) budget = '0;
        else                                 budget = USED_W'(ISSUE_W) - used_slots;
    end

    assign alloc_go = disp_valid && !full && !sq_valid && any_free;

    iq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .free_vec (free_vec),
        .pick     (pick),
        .any_free (any_free)
    );

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            iq_entry #(.SEQ_W(SEQ_W), .TAG_W(TAG_W), .NSRC(NSRC)) u_entry (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc     (alloc_go && pick[i]),
                .a_seq     (disp_seq),
                .a_dst     (disp_dst),
                .a_nonspec (disp_nonspec),
                .a_tag     (disp_src_tag),
                .a_rdy     (disp_src_rdy),
                .wk_valid  (wake_valid),
                .wk_tag    (wake_tag),
                .rel_valid (rel_valid),
                .rel_seq   (rel_seq),
                .sq_valid  (sq_valid),
                .sq_seq    (sq_seq),
                .issue_go  (grant[i] && out_ready),
                .st_o      (st_arr[i]),
                .seq_o     (seq_arr[i]),
                .dst_o     (dst_arr[i])
            );
        end
    endgenerate

    iq_select #(
        .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W),
        .TAG_W(TAG_W), .BUD_W(USED_W)
    ) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_vec  (ready_vec),
        .seq_arr    (seq_arr),
        .dst_arr    (dst_arr),
        .budget     (budget),
        .grant      (grant),
        .lane_valid (out_valid),
        .lane_seq   (out_seq),
        .lane_dst   (out_dst)
    );

    // R11: occupancy bounded by the slot count
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        occ_count <= CNT_W'(DEPTH));

    // R10: a dispatch offered while full never raises occupancy
    p_full_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && disp_valid) |=> (occ_count <= $past(occ_count)));

    // R5: lane count within budget
    p_lane_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) <= int'(budget));

    generate
        for (genvar k = 1; k < ISSUE_W; k++) begin : g_pack
            // R5: lanes fill without gaps
            p_lane_pack_r5: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[k] |-> out_valid[k-1]);
        end
    endgenerate

endmodule

// File: tb/test_issue_queue.sv
`timescale 1ns/1ps
module test_issue_queue;

    localparam int D  = 8;
    localparam int IW = 2;
    localparam int MF = 0, MW = 1, MR = 2, MH = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            disp_valid = 0;
    logic [3:0]      disp_seq = 0;
    logic [4:0]      disp_dst = 0;
    logic            disp_nonspec = 0;
    logic [1:0][4:0] disp_src_tag = '0;
    logic [1:0]      disp_src_rdy = 0;
    logic            wake_valid = 0;
    logic [4:0]      wake_tag = 0;
    logic            rel_valid = 0;
    logic [3:0]      rel_seq = 0;
    logic            sq_valid = 0;
    logic [3:0]      sq_seq = 0;
    logic [1:0]      used_slots = 0;
    logic            out_ready = 1;
    logic [1:0]      out_valid;
    logic [1:0][3:0] out_seq;
    logic [1:0][4:0] out_dst;
    logic [3:0]      occ_count;
    logic            full;

    always #2 clk = ~clk;   // 250 MHz

    issue_queue i_issue_queue (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_seq(disp_seq),
        .disp_dst(disp_dst), .disp_nonspec(disp_nonspec), .disp_src_tag(disp_src_tag),
        .disp_src_rdy(disp_src_rdy), .wake_valid(wake_valid), .wake_tag(wake_tag),
        .rel_valid(rel_valid), .rel_seq(rel_seq), .sq_valid(sq_valid), .sq_seq(sq_seq),
        .used_slots(used_slots), .out_ready(out_ready), .out_valid(out_valid),
        .out_seq(out_seq), .out_dst(out_dst), .occ_count(occ_count), .full(full)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model
    int         m_st  [D];
    logic [3:0] m_seq [D];
    logic [4:0] m_dst [D];
    logic [4:0] m_tag [D][2];
    bit         m_rdy [D][2];
    bit         e_v   [IW];
    int         e_idx [IW];
    bit         acc;
    logic [3:0] next_seq = 0;

    function automatic bit younger(logic [3:0] a, logic [3:0] b);
        logic [3:0] d;
        d = a - b;
        return (d != 0) && !d[3];
    endfunction

    function automatic int m_count();
        int c = 0;
        for (int j = 0; j < D; j++) if (m_st[j] != MF) c++;
        return c;
    endfunction

    function automatic int m_oldest();
        int o = -1;
        for (int j = 0; j < D; j++)
            if (m_st[j] != MF && (o < 0 || younger(m_seq[o], m_seq[j]))) o = j;
        return o;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic calc_exp();
        bit taken [D];
        int bud;
        for (int j = 0; j < D; j++) taken[j] = 0;
        bud = (int'(used_slots) >= IW) ? 0 : IW - int'(used_slots);
        for (int k = 0; k < IW; k++) begin
            int best = -1;
            e_v[k] = 0;
            e_idx[k] = 0;
            if (k < bud) begin
                for (int j = 0; j < D; j++)
                    if (m_st[j] == MR && !taken[j] &&
                        (best < 0 || younger(m_seq[best], m_seq[j]))) best = j;
                if (best >= 0) begin
                    e_v[k] = 1; e_idx[k] = best; taken[best] = 1;
                end
            end
        end
    endtask

    task automatic model_update();
        int c0 = m_count();
        acc = 0;
        if (sq_valid)
            for (int j = 0; j < D; j++)
                if (m_st[j] != MF && younger(m_seq[j], sq_seq)) m_st[j] = MF;
        if (out_ready)
            for (int k = 0; k < IW; k++) if (e_v[k]) m_st[e_idx[k]] = MF;
        for (int j = 0; j < D; j++) begin
            if (m_st[j] == MW || m_st[j] == MH) begin
                for (int s = 0; s < 2; s++)
                    if (wake_valid && m_tag[j][s] == wake_tag) m_rdy[j][s] = 1;
                if (m_st[j] == MW && m_rdy[j][0] && m_rdy[j][1]) m_st[j] = MR;
                else if (m_st[j] == MH && rel_valid && rel_seq == m_seq[j]) m_st[j] = MR;
            end
        end
        if (disp_valid && !sq_valid && c0 < D) begin
            int f = -1;
            for (int j = 0; j < D; j++) if (f < 0 && m_st[j] == MF) f = j;
            if (f >= 0) begin
                acc = 1;
                m_seq[f] = disp_seq;
                m_dst[f] = disp_dst;
                for (int s = 0; s < 2; s++) begin
                    m_tag[f][s] = disp_src_tag[s];
                    m_rdy[f][s] = disp_src_rdy[s] || (wake_valid && disp_src_tag[s] == wake_tag);
                end
                if (disp_nonspec) m_st[f] = MH;
                else if (m_rdy[f][0] && m_rdy[f][1]) m_st[f] = MR;
                else m_st[f] = MW;
            end
        end
    endtask

    // inputs are set at the falling edge; outputs checked 1 ns later
    task automatic step(string tag);
        #1;
        calc_exp();
        for (int k = 0; k < IW; k++) begin
            chk(out_valid[k] == e_v[k], tag, $sformatf("lane%0d valid", k),
                int'(out_valid[k]), int'(e_v[k]));
            if (e_v[k]) begin
                chk(out_seq[k] == m_seq[e_idx[k]], tag, $sformatf("lane%0d seq", k),
                    int'(out_seq[k]), int'(m_seq[e_idx[k]]));
                chk(out_dst[k] == m_dst[e_idx[k]], tag, $sformatf("lane%0d dst", k),
                    int'(out_dst[k]), int'(m_dst[e_idx[k]]));
            end
        end
        chk(int'(occ_count) == m_count(), tag, "occ_count", int'(occ_count), m_count());
        chk(full == (m_count() == D), tag, "full", int'(full), int'(m_count() == D));
        @(posedge clk);
        model_update();
        if (acc) next_seq = next_seq + 4'd1;
        @(negedge clk);
    endtask

    task automatic idle();
        disp_valid = 0; wake_valid = 0; rel_valid = 0; sq_valid = 0;
        disp_nonspec = 0; used_slots = 0;
    endtask

    task automatic disp(logic [4:0] dst, bit ns, logic [4:0] t0, bit r0,
                        logic [4:0] t1, bit r1);
        disp_valid = 1; disp_seq = next_seq; disp_dst = dst; disp_nonspec = ns;
        disp_src_tag[0] = t0; disp_src_tag[1] = t1;
        disp_src_rdy = {r1, r0};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int j = 0; j < D; j++) m_st[j] = MF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(out_valid == 2'b00, "R1", "out_valid", int'(out_valid), 0);
        chk(occ_count == 0, "R1", "occ_count", int'(occ_count), 0);
        chk(full == 0, "R1", "full", int'(full), 0);
        @(negedge clk);
        step("R1");

        // R2: ready entry offered next cycle; R7 hold and accept
        out_ready = 0;
        disp(5'd1, 0, 5'd20, 1, 5'd21, 1); step("R2");
        idle(); step("R2");
        step("R7");
        out_ready = 1; step("R7");
        step("R7");

        // R3: wake-up of a missing source; wake in dispatch cycle
        disp(5'd2, 0, 5'd3, 0, 5'd4, 1); step("R3");
        idle(); step("R3");
        wake_valid = 1; wake_tag = 5'd9; step("R3");
        wake_tag = 5'd3; step("R3");
        idle(); step("R3");
        disp(5'd3, 0, 5'd6, 0, 5'd6, 1); wake_valid = 1; wake_tag = 5'd6; step("R3");
        idle(); step("R3");
        step("R3");

        // R4: non-speculative held until exact release
        disp(5'd4, 1, 5'd1, 1, 5'd1, 1); step("R4");
        idle(); step("R4");
        rel_valid = 1; rel_seq = next_seq + 4'd5; step("R4");
        rel_seq = next_seq - 4'd1; step("R4");
        idle(); step("R4");
        step("R4");

        // R5: budget and saturation
        out_ready = 0;
        for (int n = 0; n < 3; n++) begin disp(5'(10 + n), 0, 0, 1, 0, 1); step("R5"); end
        idle();
        for (int u = 0; u < 4; u++) begin used_slots = 2'(u); step("R5"); end
        used_slots = 0; out_ready = 1; step("R6"); step("R6"); step("R6");

        // R12 / R6: wrap-aware oldest-first, dispatched in reverse age order
        out_ready = 0;
        next_seq = 4'd1;  disp(5'd21, 0, 0, 1, 0, 1); step("R12");
        next_seq = 4'd0;  disp(5'd20, 0, 0, 1, 0, 1); step("R12");
        next_seq = 4'd15; disp(5'd19, 0, 0, 1, 0, 1); step("R12");
        next_seq = 4'd14; disp(5'd18, 0, 0, 1, 0, 1); step("R12");
        idle(); step("R12");
        chk(out_seq[0] == 4'd14 && out_seq[1] == 4'd15, "R12", "wrap order",
            int'(out_seq[0]), 14);
        out_ready = 1; step("R6"); step("R6"); step("R6");
        next_seq = 4'd2;

        // R8 / R9: selective squash with wake, release, dispatch same cycle
        out_ready = 0;
        disp(5'd1, 0, 5'd7, 0, 5'd7, 1); step("R8");   // seq 2 waits
        disp(5'd2, 0, 5'd0, 1, 5'd0, 1); step("R8");   // seq 3 ready
        disp(5'd3, 1, 5'd0, 1, 5'd0, 1); step("R8");   // seq 4 held
        disp(5'd4, 0, 5'd9, 0, 5'd9, 1); step("R8");   // seq 5 waits
        disp(5'd5, 0, 5'd0, 1, 5'd0, 1); step("R8");   // seq 6 ready
        disp(5'd6, 0, 5'd0, 1, 5'd0, 1);               // seq 7 dropped
        sq_valid = 1; sq_seq = 4'd3; wake_valid = 1; wake_tag = 5'd9;
        rel_valid = 1; rel_seq = 4'd4; step("R9");
        idle(); step("R8");
        chk(occ_count == 2, "R8", "survivors", int'(occ_count), 2);
        chk(out_valid == 2'b01 && out_seq[0] == 4'd3, "R9", "only seq3 offered",
            int'(out_valid), 1);
        next_seq = 4'd4;
        wake_valid = 1; wake_tag = 5'd7; out_ready = 1; step("R8");
        idle(); step("R8"); step("R8");

        // R10 / R11: fill, overflow attempt, partial squash
        out_ready = 0;
        for (int n = 0; n < D; n++) begin disp(5'(n), 0, 5'd10, 0, 5'd10, 0); step("R11"); end
        disp(5'd30, 0, 0, 1, 0, 1); step("R10");
        idle(); step("R10");
        chk(full == 1 && occ_count == 4'd8, "R10", "full after fill", int'(occ_count), 8);
        sq_valid = 1; sq_seq = 4'd4; step("R8");
        idle(); step("R11");
        next_seq = 4'd5;
        wake_valid = 1; wake_tag = 5'd10; out_ready = 1; step("R3");
        idle(); step("R11"); step("R11");

        // random mix
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int o;
            idle();
            o = m_oldest();
            out_ready  = ($urandom_range(0, 3) != 0);
            used_slots = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 9) < 6 &&
                (o < 0 || int'(4'(next_seq - m_seq[o])) <= 6))
                disp(5'($urandom_range(0, 31)), ($urandom_range(0, 6) == 0),
                     5'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
                     5'($urandom_range(0, 7)), bit'($urandom_range(0, 1)));
            if ($urandom_range(0, 9) < 4) begin
                wake_valid = 1; wake_tag = 5'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 4) == 0) begin
                int st0 = $urandom_range(0, D - 1);
                for (int j = 0; j < D; j++) begin
                    int x = (st0 + j) % D;
                    if (!rel_valid && m_st[x] == MH) begin
                        rel_valid = 1; rel_seq = m_seq[x];
                    end
                end
            end
            if ($urandom_range(0, 24) == 0 && o >= 0) begin
                int st0 = $urandom_range(0, D - 1);
                for (int j = 0; j < D; j++) begin
                    int x = (st0 + j) % D;
                    if (!sq_valid && m_st[x] != MF) begin
                        sq_valid = 1; sq_seq = m_seq[x];
                    end
                end
            end
            step("R6 random");
            if (sq_valid) next_seq = sq_seq + 4'd1;
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule